// File: doc/BRIEF.md
# Multi-Channel Interval Timer

This peripheral holds four independent 32-bit down-counters behind a zero-wait APB-style register bus. Each channel has its own 0x40-byte register window. Software writes a start value, picks continuous or single-run mode and turns the channel on. The channel then counts down once for every bus-clock cycle in which its tick-enable input is high. On reaching zero it raises a sticky pending flag, which drives a maskable interrupt line. In continuous mode the channel reloads itself and keeps running. In single-run mode it stops and switches itself off.

A pending flag is removed through a short clear sequence rather than a single write. Starting a clear sets a busy indication. The flag and the busy indication drop together a fixed number of cycles later. Clear requests that arrive while a clear is in flight are dropped. A shared read-only word collects the pending flags of all channels, so one read can find which channel needs service.

Top module: `tick_timer_bank`

## Requirements
- R1: Channel n is decoded at byte addresses n*0x40 to n*0x40+0x3F. Inside a window, 0x04 is mode, 0x08 is start value, 0x10 is run, 0x14 is restart, 0x18 is count (read-only), 0x20 is clear and 0x24 is mask. Other offsets read 0 and ignore writes, and the restart register reads 0. A write reaches only the addressed channel.
- R2: Offset 0x00 of any window reads a word whose bit n is the pending flag of channel n. Writes to it are ignored.
- R3: After reset, every register and count reads 0 except mask, which reads 1. Writing the start value does not change the count.
- R4: While run bit 0 is 1 and the channel's tick input is high, the count falls by one each cycle. While run is 0, the count holds.
- R5: Any write to the restart register, whatever its data, copies the start value into the count at that clock edge, whether or not the channel is running.
- R6: In continuous mode (mode bit 0 = 0), the edge that brings the count to zero sets the pending flag. On the following edge the count reloads from the start value, whatever the tick input, and run stays 1.
- R7: In single-run mode (mode bit 0 = 1), the edge that brings the count to zero sets the pending flag and clears run. The count then stays at zero under further ticks.
- R8: A channel's interrupt output is high exactly when its pending flag is 1 and mask bit 0 is 0.
- R9: Clear register bit 0 reads the pending flag and bit 1 reads busy. Writing 1 to bit 0 while idle sets busy for 4 cycles, after which pending and busy drop on the same edge. Writing 0 has no effect.
- R10: A clear write that arrives while busy is 1 is ignored and does not extend the busy period.
- R11: Channels are independent: counting, expiry and clearing on one channel leave the others unchanged.
- R12: With its tick input low, a running channel keeps its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| pSel | input | 1 | Peripheral select |
| pEnable | input | 1 | Access phase of a transfer |
| pWrite | input | 1 | 1 for write, 0 for read |
| pAddr | input | ADDR_W (8) | Byte address |
| pWdata | input | DATA_W (32) | Write data |
| pRdata | output | DATA_W (32) | Read data, combinational from pAddr |
| tickEn | input | NUM_CH (4) | Per-channel count enable, one bit per channel |
| irq | output | NUM_CH (4) | Per-channel interrupt lines |

## Verification
A miscounting channel shows its fault through the count register and, more sharply, through the cycle on which its interrupt line rises. The bench pins the number of ticks fed to the channel, so an off-by-one decrement or reload moves that edge by one cycle. A clear sequencer of the wrong length makes the interrupt line fall one cycle early or late relative to the clear write, and the bench samples it on both sides of the expected edge. A clear write that is wrongly accepted while busy delays the fall by several cycles. Decode faults show on the next read of an untouched neighbour register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned WIN_W = 6;

  typedef enum logic [WIN_W-1:0] {
    OFS_STAT   = 6'h00,
    OFS_MODE   = 6'h04,
    OFS_LOAD   = 6'h08,
    OFS_RUN    = 6'h10,
    OFS_RELOAD = 6'h14,
    OFS_VALUE  = 6'h18,
    OFS_CLR    = 6'h20,
    OFS_MASK   = 6'h24
  } regOfs_e;

  typedef struct packed {
    logic wrMode;
    logic wrLoad;
    logic wrRun;
    logic wrReload;
    logic wrClr;
    logic wrMask;
  } chanStb_t;

  typedef struct packed {
    logic mode;
    logic run;
    logic pend;
    logic busy;
    logic mask;
  } chanFlags_t;

endpackage

// File: rtl/tmr_bus_ctrl.sv
module tmr_bus_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          pSel,
  input  logic                          pEnable,
  input  logic                          pWrite,
  input  logic [ADDR_W-1:0]             pAddr,
  input  chanFlags_t [NUM_CH-1:0]       flags,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  loadVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  countVal,
  output chanStb_t [NUM_CH-1:0]         stb,
  output logic [DATA_W-1:0]             pRdata
);

  localparam int unsigned UP_W = ADDR_W - WIN_W;
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [WIN_W-1:0]  ofs;
  logic [UP_W-1:0]   upper;
  logic [CH_W-1:0]   chIdx;
  logic              inRange;
  logic              wrAcc;
  logic [NUM_CH-1:0] pendVec;
  logic [NUM_CH-1:0] anyStb;

  assign ofs     = pAddr[WIN_W-1:0];
  assign upper   = pAddr[ADDR_W-1:WIN_W];
  assign chIdx   = upper[CH_W-1:0];
  assign inRange = (int'(upper) < NUM_CH);
  assign wrAcc   = pSel && pEnable && pWrite;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_stb
    logic hit;
    assign hit             = wrAcc && inRange && (chIdx == CH_W'(c));
    assign stb[c].wrMode   = hit && (ofs == OFS_MODE);
    assign stb[c].wrLoad   = hit && (ofs == OFS_LOAD);
    assign stb[c].wrRun    = hit && (ofs == OFS_RUN);
    assign stb[c].wrReload = hit && (ofs == OFS_RELOAD);
    assign stb[c].wrClr    = hit && (ofs == OFS_CLR);
    assign stb[c].wrMask   = hit && (ofs == OFS_MASK);
    assign pendVec[c]      = flags[c].pend;
    assign anyStb[c]       = |stb[c];
  end

  // Read path: zero-wait, selected straight from the address (R1, R2)
  always_comb begin
    pRdata = '0;
    if (inRange) begin
      case (ofs)
        OFS_STAT:  pRdata[NUM_CH-1:0] = pendVec;
        OFS_MODE:  pRdata[0] = flags[chIdx].mode;
        OFS_LOAD:  pRdata[CNT_W-1:0] = loadVal[chIdx];
        OFS_RUN:   pRdata[0] = flags[chIdx].run;
        OFS_VALUE: pRdata[CNT_W-1:0] = countVal[chIdx];
        OFS_CLR:   pRdata[1:0] = {flags[chIdx].busy, flags[chIdx].pend};
        OFS_MASK:  pRdata[0] = flags[chIdx].mask;
        default:   pRdata = '0;
      endcase
    end
  end

  // R1: a bus write never touches more than one channel
  a_r1_one_channel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(anyStb));

  // R1: no strobe without an access-phase write
  a_r1_strobe_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (|anyStb) |-> (pSel && pEnable && pWrite));

endmodule

// File: rtl/tmr_chan_dp.sv
module tmr_chan_dp
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CLR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  chanStb_t          stb,
  input  logic [DATA_W-1:0] wdata,
  output chanFlags_t        flags,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  countVal,
  output logic              irq
);

  localparam int unsigned CLR_W = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;

  logic             mode;
  logic             run;
  logic             pend;
  logic             busy;
  logic             mask;
  logic [CNT_W-1:0] loadReg;
  logic [CNT_W-1:0] count;
  logic [CLR_W-1:0] clrCnt;
  logic             atZero;
  logic             expire;
  logic             clrStart;
  logic             clrDone;

  assign atZero   = (count == '0);
  assign expire   = run && !stb.wrReload && (atZero || (tickEn && count == CNT_W'(1)));
  assign clrStart = stb.wrClr && wdata[0] && !busy;
  assign clrDone  = busy && (clrCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= 1'b0;
      run     <= 1'b0;
      pend    <= 1'b0;
      busy    <= 1'b0;
      mask    <= 1'b1;
      loadReg <= '0;
      count   <= '0;
      clrCnt  <= '0;
    end else begin
      if (stb.wrMode) mode <= wdata[0];
      if (stb.wrLoad) loadReg <= wdata[CNT_W-1:0];
      if (stb.wrMask) mask <= wdata[0];

      // counter: restart write first, then auto-reload or decrement
      if (stb.wrReload) begin
        count <= loadReg;
      end else if (run) begin
        if (atZero) begin
          if (!mode) count <= loadReg;
        end else if (tickEn) begin
          count <= count - CNT_W'(1);
        end
      end

      // run bit: bus write wins over single-run self stop
      if (stb.wrRun) run <= wdata[0];
      else if (expire && mode) run <= 1'b0;

      // clear sequencer
      if (busy) begin
        if (clrDone) busy <= 1'b0;
        else clrCnt <= clrCnt - CLR_W'(1);
      end else if (clrStart) begin
        busy   <= 1'b1;
        clrCnt <= CLR_W'(CLR_CYCLES - 1);
      end

      // pending: a new expiry outranks a finishing clear
      if (expire) pend <= 1'b1;
      else if (clrDone) pend <= 1'b0;
    end
  end

  assign flags    = '{mode: mode, run: run, pend: pend, busy: busy, mask: mask};
  assign loadVal  = loadReg;
  assign countVal = count;
  assign irq      = pend && !mask;

  // checker-side length counter for the busy window
  logic [CLR_W:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !stb.wrReload) |=> $stable(count));

  a_r5_restart_copies: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrReload |=> (count == $past(loadReg)));

  a_r6_cont_reload: assert property (@(posedge clk) disable iff (!rstN)
    (run && !mode && atZero && !stb.wrReload) |=> (count == $past(loadReg) && pend));

  a_r7_single_stop: assert property (@(posedge clk) disable iff (!rstN)
    (run && mode && tickEn && count == CNT_W'(1) && !stb.wrReload && !stb.wrRun)
      |=> (!run && atZero && pend));

  // R9, R10: busy always lasts exactly CLR_CYCLES cycles
  a_r9_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == (CLR_W+1)'(CLR_CYCLES)));

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CLR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWdata,
  output logic [DATA_W-1:0] pRdata,
  input  logic [NUM_CH-1:0] tickEn,
  output logic [NUM_CH-1:0] irq
);

  chanStb_t   [NUM_CH-1:0]            stb;
  chanFlags_t [NUM_CH-1:0]            flags;
  logic       [NUM_CH-1:0][CNT_W-1:0] loadVal;
  logic       [NUM_CH-1:0][CNT_W-1:0] countVal;

  tmr_bus_ctrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_bus (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .flags(flags), .loadVal(loadVal), .countVal(countVal),
    .stb(stb), .pRdata(pRdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_chan_dp #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .CLR_CYCLES(CLR_CYCLES)
    ) u_ch (
      .clk(clk), .rstN(rstN), .tickEn(tickEn[c]), .stb(stb[c]), .wdata(pWdata),
      .flags(flags[c]), .loadVal(loadVal[c]), .countVal(countVal[c]), .irq(irq[c])
    );
  end

endmodule

// File: tb/tick_timer_bank_tb_top.sv
module tick_timer_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 1'b0;
  logic        pEnable = 1'b0;
  logic        pWrite = 1'b0;
  logic [7:0]  pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic [3:0]  tickEn = '0;
  logic [3:0]  irq;

  int applied = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  tick_timer_bank dut_i (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata), .tickEn(tickEn), .irq(irq)
  );

  typedef struct packed {
    logic        isWr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 8'h04, 32'h0,    32'h0,    8'd3},  // R3 mode reset
    '{1'b0, 8'h24, 32'h0,    32'h1,    8'd8},  // R8 mask resets to 1
    '{1'b0, 8'h00, 32'h0,    32'h0,    8'd2},  // R2 no pending
    '{1'b0, 8'h58, 32'h0,    32'h0,    8'd3},  // R3 ch1 count reset
    '{1'b1, 8'h48, 32'h1234, 32'h0,    8'd0},
    '{1'b0, 8'h48, 32'h0,    32'h1234, 8'd3},  // R3 start value
    '{1'b0, 8'h58, 32'h0,    32'h0,    8'd3},  // R3 count untouched
    '{1'b1, 8'h54, 32'h0,    32'h0,    8'd0},
    '{1'b0, 8'h58, 32'h0,    32'h1234, 8'd5},  // R5 restart with data 0
    '{1'b0, 8'h18, 32'h0,    32'h0,    8'd11}, // R11 ch0 untouched
    '{1'b1, 8'h84, 32'h1,    32'h0,    8'd0},
    '{1'b0, 8'h84, 32'h0,    32'h1,    8'd1},  // R1 ch2 mode
    '{1'b0, 8'hC4, 32'h0,    32'h0,    8'd1},  // R1 ch3 mode untouched
    '{1'b1, 8'hCC, 32'hFFFF, 32'h0,    8'd0},
    '{1'b0, 8'hCC, 32'h0,    32'h0,    8'd1},  // R1 unmapped reads 0
    '{1'b0, 8'hC8, 32'h0,    32'h0,    8'd1},  // R1 unmapped write ignored
    '{1'b1, 8'h50, 32'h1,    32'h0,    8'd0},
    '{1'b0, 8'h50, 32'h0,    32'h1,    8'd4},  // R4 run bit
    '{1'b0, 8'h58, 32'h0,    32'h1234, 8'd12}, // R12 tick low holds
    '{1'b0, 8'h54, 32'h0,    32'h0,    8'd1}   // R1 restart reads 0
  };

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] expv);
    applied++;
    if (got !== expv) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", req, got, expv);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    pSel = 1'b1; pWrite = 1'b1; pAddr = a; pWdata = d; pEnable = 1'b0;
    @(negedge clk);
    pEnable = 1'b1;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    pSel = 1'b1; pWrite = 1'b0; pAddr = a; pEnable = 1'b0;
    @(negedge clk);
    pEnable = 1'b1;
    #1 d = pRdata;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0;
  endtask

  task automatic tickPulse(input int ch, input int n);
    @(negedge clk);
    tickEn[ch] = 1'b1;
    repeat (n) @(negedge clk);
    tickEn[ch] = 1'b0;
  endtask

  task automatic rdChk(input int req, input logic [7:0] a, input logic [31:0] expv);
    logic [31:0] v;
    busRead(a, v);
    chk(req, v, expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(8, {28'b0, irq}, 32'h0);  // R8 no interrupt after reset

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isWr) busWrite(VECS[i].addr, VECS[i].data);
      else rdChk(int'(VECS[i].req), VECS[i].addr, VECS[i].expv);
    end

    // R4: five ticks on running ch1, then hold once stopped
    tickPulse(1, 5);
    rdChk(4, 8'h58, 32'h122F);
    busWrite(8'h50, 32'h0);
    tickPulse(1, 3);
    rdChk(4, 8'h58, 32'h122F);

    // R6: ch0 continuous, start value 3
    busWrite(8'h08, 32'd3);
    busWrite(8'h14, 32'hDEAD);
    busWrite(8'h24, 32'h0);
    busWrite(8'h10, 32'h1);
    tickPulse(0, 2);
    chk(6, {31'b0, irq[0]}, 32'h0);   // R6 count at 1, no event yet
    tickPulse(0, 1);
    chk(6, {31'b0, irq[0]}, 32'h1);   // R6 event on reaching zero
    rdChk(6, 8'h18, 32'd3);           // R6 reloaded without a tick
    rdChk(6, 8'h10, 32'h1);           // R6 still running

    // R8: masking
    busWrite(8'h24, 32'h1);
    chk(8, {31'b0, irq[0]}, 32'h0);
    rdChk(8, 8'h20, 32'h1);
    busWrite(8'h24, 32'h0);
    chk(8, {31'b0, irq[0]}, 32'h1);

    // R7: ch2 single run, start value 2
    busWrite(8'h88, 32'd2);
    busWrite(8'h94, 32'h0);
    busWrite(8'hA4, 32'h0);
    busWrite(8'h90, 32'h1);
    tickPulse(2, 2);
    chk(7, {31'b0, irq[2]}, 32'h1);
    rdChk(7, 8'h90, 32'h0);
    rdChk(7, 8'h98, 32'h0);
    tickPulse(2, 3);
    rdChk(7, 8'h98, 32'h0);
    chk(11, {30'b0, irq[3], irq[1]}, 32'h0);  // R11 other channels quiet

    // R2: status word from several windows, write ignored
    rdChk(2, 8'h00, 32'h5);
    rdChk(2, 8'h40, 32'h5);
    busWrite(8'h00, 32'h0);
    rdChk(2, 8'h00, 32'h5);

    // R9: clear on ch0
    busWrite(8'h20, 32'h0);
    rdChk(9, 8'h20, 32'h1);           // R9 writing 0 does nothing
    busWrite(8'h20, 32'h1);
    rdChk(9, 8'h20, 32'h3);           // R9 busy and pending
    chk(9, {31'b0, irq[0]}, 32'h1);   // R9 three cycles after start
    @(negedge clk);
    chk(9, {31'b0, irq[0]}, 32'h0);   // R9 drops after four
    rdChk(9, 8'h20, 32'h0);
    rdChk(2, 8'h00, 32'h4);

    // R10: second clear during busy on ch2
    busWrite(8'hA0, 32'h1);
    busWrite(8'hA0, 32'h1);
    chk(10, {31'b0, irq[2]}, 32'h1);
    @(negedge clk);
    chk(10, {31'b0, irq[2]}, 32'h0);
    rdChk(10, 8'hA0, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    applied++;
    $display("FAIL R0: watchdog expired, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule